// File: doc/BRIEF.md
# Glitch-Free Five-Source Clock Switch

This block picks one of five incoming clocks and drives it onto a single domain clock output. When the chosen source changes, the output never shows a shortened high or low phase. A small control word sets the source: a 3-bit select in bits [2:0] is written, and the same field plus a busy flag in bit 3 is read back.

A switch runs in three steps. First the output gate of the old clock is closed in that clock's own domain. Next the control logic waits until it has seen that gate closed. Only then does it open the gate of the new clock. Each source has a two-stage enable synchronizer that runs on the falling edge of that source. As a result, a gate only opens or closes while its clock is low. The busy flag is set for the whole switch and clears once the new gate is seen open.

The parameter `FIXED_SRC` straps the block to source 4. In that build the block ignores every select write and always reports source 4 with busy clear.

Top module: `clk_src_switch`

## Requirements
- R1: After reset the read word reports select 1 (oscillator) with busy (bit 3) at 0, and `clk_out` follows source 1.
- R2: Source indices are 0 = slow real-time clock, 1 = main oscillator, 2/3/4 = first/second/third PLL. Writing a valid select in bits [2:0] that differs from the current one makes the read word report the new index at once. Once the switch completes, `clk_out` follows the source with that index.
- R3: Bit 3 of the read word is 1 from the cycle after an accepted select write. It returns to 0 only after the new source is driving `clk_out`, and within a bounded time.
- R4: Writes of select values 5, 6 or 7 are ignored. The reported select, the busy flag and `clk_out` all stay as they were.
- R5: Writing the select that is already current starts no switch, and busy stays 0.
- R6: A select write that arrives while busy is 1 is ignored, and the switch in progress completes to its original target.
- R7: At most one source gate is ever open. During a switch, `clk_out` is high only while the old or the new source is high.
- R8: With `FIXED_SRC` = 1, the block always reports select 4 with busy 0, ignores all writes, and `clk_out` follows source 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each clock domain |
| cfg_clk | input | 1 | Clock of the control word interface |
| src_clk | input | NSRC | Candidate source clocks, bit i is source index i |
| wr_en | input | 1 | Write strobe for the select field |
| wr_data | input | 3 | Select value to write |
| rd_data | output | 4 | Read word: bits [2:0] select, bit 3 busy |
| clk_out | output | 1 | Selected domain clock |

## Verification
The bench builds two copies of the block on the same stimulus. One uses the default `FIXED_SRC` = 0 with five sources, and the other uses `FIXED_SRC` = 1. Every write therefore also tests that the strapped build holds source 4. The five source half-periods range from 7 ns to 47 ns, which covers handoffs from a slow clock to a fast one and the reverse. In these handoffs the drop phase and the raise phase take very different times. The bench also samples `clk_out` against the two sources involved during each switch, to catch any high phase that neither clock explains.

// File: rtl/ckmux_pkg.sv
package ckmux_pkg;
  localparam int NUM_SRC  = 5;
  localparam int SEL_BITS = 3;
  localparam int WORD_W   = SEL_BITS + 1;
  localparam int BUSY_BIT = SEL_BITS;
  localparam int BOOT_SRC = 1;
  localparam int LOCK_SRC = 4;

  typedef enum logic [1:0] {
    SW_IDLE  = 2'd0,
    SW_DROP  = 2'd1,
    SW_RAISE = 2'd2
  } sw_state_t;
endpackage

// File: rtl/ckmux_rst_sync.sv
module ckmux_rst_sync #(
  parameter bit FALL_EDGE = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sh_q;

  generate
    if (FALL_EDGE) begin : g_fall
      always_ff @(negedge clk or negedge arst_n) begin
        if (!arst_n) sh_q <= '0;
        else         sh_q <= {sh_q[0], 1'b1};
      end
    end else begin : g_rise
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sh_q <= '0;
        else         sh_q <= {sh_q[0], 1'b1};
      end
    end
  endgenerate

  assign srst_n = sh_q[1];
endmodule

// File: rtl/ckmux_lane.sv
module ckmux_lane #(
  parameter bit RST_ON = 1'b0
) (
  input  logic rst_n,
  input  logic src_clk,
  input  logic cfg_clk,
  input  logic cfg_rst_n,
  input  logic req_i,
  output logic en_o,
  output logic ack_o,
  output logic gclk_o
);
  logic lrst_n;
  logic meta_q, en_q;
  logic ack_meta_q, ack_q;

  ckmux_rst_sync #(.FALL_EDGE(1'b1)) u_rsync (
    .clk    (src_clk),
    .arst_n (rst_n),
    .srst_n (lrst_n)
  );

  // enable crosses into the source domain on its falling edge
  always_ff @(negedge src_clk or negedge lrst_n) begin
    if (!lrst_n) begin
      meta_q <= RST_ON;
      en_q   <= RST_ON;
    end else begin
      meta_q <= req_i;
      en_q   <= meta_q;
    end
  end

  // gate state reported back to the control domain
  always_ff @(posedge cfg_clk or negedge cfg_rst_n) begin
    if (!cfg_rst_n) begin
      ack_meta_q <= RST_ON;
      ack_q      <= RST_ON;
    end else begin
      ack_meta_q <= en_q;
      ack_q      <= ack_meta_q;
    end
  end

  assign en_o   = en_q;
  assign ack_o  = ack_q;
  assign gclk_o = src_clk & en_q;
endmodule

// File: rtl/ckmux_ctrl.sv
module ckmux_ctrl
  import ckmux_pkg::*;
#(
  parameter int NSRC      = NUM_SRC,
  parameter bit FIXED_SRC = 1'b0,
  parameter int RST_SRC   = BOOT_SRC
) (
  input  logic                cfg_clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [SEL_BITS-1:0] wr_sel,
  input  logic [NSRC-1:0]     ack_i,
  output logic [NSRC-1:0]     req_o,
  output logic [SEL_BITS-1:0] sel_o,
  output logic                busy_o
);
  sw_state_t           state_q, state_d;
  logic [SEL_BITS-1:0] sel_q, sel_d;
  logic [SEL_BITS-1:0] old_q, old_d;
  logic [NSRC-1:0]     req_q, req_d;
  logic                sel_ok;
  logic                accept;

  assign sel_ok = int'(wr_sel) < NSRC;
  assign accept = wr_en && !FIXED_SRC && (state_q == SW_IDLE) && sel_ok && (wr_sel != sel_q);

  always_comb begin
    state_d = state_q;
    sel_d   = sel_q;
    old_d   = old_q;
    req_d   = req_q;
    unique case (state_q)
      SW_IDLE: begin
        if (accept) begin
          old_d   = sel_q;
          sel_d   = wr_sel;
          req_d   = '0;
          state_d = SW_DROP;
        end
      end
      SW_DROP: begin
        if (!ack_i[old_q]) begin
          for (int i = 0; i < NSRC; i++) req_d[i] = (SEL_BITS'(i) == sel_q);
          state_d = SW_RAISE;
        end
      end
      SW_RAISE: begin
        if (ack_i[sel_q]) state_d = SW_IDLE;
      end
      default: state_d = SW_IDLE;
    endcase
  end

  always_ff @(posedge cfg_clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SW_IDLE;
      sel_q   <= SEL_BITS'(RST_SRC);
      old_q   <= SEL_BITS'(RST_SRC);
      for (int i = 0; i < NSRC; i++) req_q[i] <= (i == RST_SRC);
    end else begin
      state_q <= state_d;
      sel_q   <= sel_d;
      old_q   <= old_d;
      req_q   <= req_d;
    end
  end

  assign req_o  = req_q;
  assign sel_o  = sel_q;
  assign busy_o = (state_q != SW_IDLE);

  AST_BAD_SEL_KEPT: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    (wr_en && !sel_ok) |=> $stable(sel_q)) else $error("bad select changed state"); // R4
  AST_BUSY_WR_KEPT: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    (busy_o && wr_en) |=> $stable(sel_q)) else $error("write during switch taken"); // R6
  AST_ACK_EXCL: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    $countones(ack_i) <= 1) else $error("two gates reported open"); // R7
  AST_STRAP_HELD: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    FIXED_SRC |-> (int'(sel_q) == RST_SRC && !busy_o)) else $error("strapped select moved"); // R8
endmodule

// File: rtl/clk_src_switch.sv
module clk_src_switch
  import ckmux_pkg::*;
#(
  parameter int NSRC      = NUM_SRC,
  parameter bit FIXED_SRC = 1'b0
) (
  input  logic                rst_n,
  input  logic                cfg_clk,
  input  logic [NSRC-1:0]     src_clk,
  input  logic                wr_en,
  input  logic [SEL_BITS-1:0] wr_data,
  output logic [WORD_W-1:0]   rd_data,
  output logic                clk_out
);
  localparam int RST_SRC = FIXED_SRC ? LOCK_SRC : BOOT_SRC;

  logic                cfg_rst_n;
  logic [NSRC-1:0]     req_vec, en_vec, ack_vec, gclk_vec;
  logic [SEL_BITS-1:0] sel;
  logic                busy;

  ckmux_rst_sync #(.FALL_EDGE(1'b0)) u_cfg_rsync (
    .clk    (cfg_clk),
    .arst_n (rst_n),
    .srst_n (cfg_rst_n)
  );

  ckmux_ctrl #(
    .NSRC      (NSRC),
    .FIXED_SRC (FIXED_SRC),
    .RST_SRC   (RST_SRC)
  ) u_ctrl (
    .cfg_clk (cfg_clk),
    .rst_n   (cfg_rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_data),
    .ack_i   (ack_vec),
    .req_o   (req_vec),
    .sel_o   (sel),
    .busy_o  (busy)
  );

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_lane
      ckmux_lane #(.RST_ON(1'(i == RST_SRC))) u_lane (
        .rst_n     (rst_n),
        .src_clk   (src_clk[i]),
        .cfg_clk   (cfg_clk),
        .cfg_rst_n (cfg_rst_n),
        .req_i     (req_vec[i]),
        .en_o      (en_vec[i]),
        .ack_o     (ack_vec[i]),
        .gclk_o    (gclk_vec[i])
      );
    end
  endgenerate

  assign clk_out = |gclk_vec;
  always_comb begin
    rd_data                 = '0;
    rd_data[SEL_BITS-1:0]   = sel;
    rd_data[BUSY_BIT]       = busy;
  end

  AST_ONE_GATE: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
    $onehot0(en_vec)) else $error("two source gates open"); // R7
  AST_DONE_DRIVEN: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
    $fell(busy) |-> en_vec[sel]) else $error("busy cleared before new gate open"); // R3
endmodule

// File: tb/clk_src_switch_tb.sv
module clk_src_switch_tb_top;
  timeunit 1ns;
  timeprecision 100ps;

  typedef struct {
    bit          fix;
    logic [2:0]  sel;
    string       tag;
  } exp_t;

  logic       cfg_clk = 1'b0;
  logic       rst_n   = 1'b0;
  logic       s0 = 1'b0, s1 = 1'b0, s2 = 1'b0, s3 = 1'b0, s4 = 1'b0;
  logic [4:0] srcv;
  logic       wr_en   = 1'b0;
  logic [2:0] wr_data = 3'd0;
  logic [3:0] rd_main, rd_fix;
  logic       clk_main, clk_fix;

  int   n_chk = 0;
  int   n_bad = 0;
  int   foreign = 0;
  int   watch_a = 1;
  int   watch_b = 1;
  exp_t q[$];

  assign srcv = {s4, s3, s2, s1, s0};

  always #10 cfg_clk = ~cfg_clk;
  always #47 s0 = ~s0;
  always #15 s1 = ~s1;
  always #7  s2 = ~s2;
  always #11 s3 = ~s3;
  always #9  s4 = ~s4;

  clk_src_switch #(.NSRC(5), .FIXED_SRC(1'b0)) dut_i (
    .rst_n (rst_n), .cfg_clk (cfg_clk), .src_clk (srcv),
    .wr_en (wr_en), .wr_data (wr_data), .rd_data (rd_main), .clk_out (clk_main)
  );

  clk_src_switch #(.NSRC(5), .FIXED_SRC(1'b1)) dut_fix_i (
    .rst_n (rst_n), .cfg_clk (cfg_clk), .src_clk (srcv),
    .wr_en (wr_en), .wr_data (wr_data), .rd_data (rd_fix), .clk_out (clk_fix)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor: pops expected items and compares against the outputs
  initial begin : monitor
    exp_t       it;
    logic [3:0] rd;
    int         mism;
    forever begin
      wait (q.size() > 0);
      it = q[0];
      rd = it.fix ? rd_fix : rd_main;
      chk(rd[2:0] == it.sel, it.tag, "select readback", int'(rd[2:0]), int'(it.sel));
      chk(rd[3] == 1'b0, it.tag, "busy settled", int'(rd[3]), 0);
      mism = 0;
      #0.5;
      for (int k = 0; k < 250; k++) begin
        #1;
        if ((it.fix ? clk_fix : clk_main) !== srcv[it.sel]) mism++;
      end
      chk(mism == 0, it.tag, "output follows source", mism, 0);
      void'(q.pop_front());
    end
  end

  // watcher: a high output phase must come from the old or the new source
  initial begin : watcher
    #0.5;
    forever begin
      #1;
      if (rst_n && clk_main && !srcv[watch_a] && !srcv[watch_b]) foreign++;
    end
  end

  task automatic expect_both(input logic [2:0] sel, input string tag);
    exp_t a, b;
    a.fix = 1'b0; a.sel = sel;  a.tag = tag;
    b.fix = 1'b1; b.sel = 3'd4; b.tag = "R8";
    q.push_back(a);
    q.push_back(b);
    wait (q.size() == 0);
  endtask

  task automatic put_sel(input logic [2:0] d);
    @(negedge cfg_clk);
    wr_en   = 1'b1;
    wr_data = d;
    @(negedge cfg_clk);
    wr_en   = 1'b0;
    wr_data = 3'd0;
  endtask

  task automatic wait_idle(input string tag);
    int cyc = 0;
    while (rd_main[3] && cyc < 400) begin
      @(negedge cfg_clk);
      cyc++;
    end
    chk(cyc < 400, tag, "busy clears in time", cyc, 400);
  endtask

  task automatic do_switch(input logic [2:0] to, input string tag);
    int f0 = foreign;
    watch_b = int'(to);
    put_sel(to);
    chk(rd_main[3] == 1'b1, "R3", "busy after accepted write", int'(rd_main[3]), 1);
    chk(rd_main[2:0] == to, tag, "target reported at once", int'(rd_main[2:0]), int'(to));
    chk(rd_fix == 4'd4, "R8", "strapped build ignores write", int'(rd_fix), 4);
    wait_idle("R3");
    chk(foreign == f0, "R7", "no foreign high phase", foreign - f0, 0);
    watch_a = int'(to);
    expect_both(to, tag);
  endtask

  task automatic do_ignored(input logic [2:0] d, input logic [2:0] cur, input string tag);
    put_sel(d);
    chk(rd_main[3] == 1'b0, tag, "no busy on ignored write", int'(rd_main[3]), 0);
    chk(rd_main[2:0] == cur, tag, "select kept", int'(rd_main[2:0]), int'(cur));
    expect_both(cur, tag);
  endtask

  initial begin : watchdog
    #3_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : driver
    int f0;
    repeat (5) @(negedge cfg_clk);
    rst_n = 1'b1;
    repeat (6) @(negedge cfg_clk);
    // R1 reset state
    chk(rd_main == 4'b0001, "R1", "reset read word", int'(rd_main), 1);
    expect_both(3'd1, "R1");

    // R2 switches across the source set, including the slow clock
    do_switch(3'd2, "R2");
    do_switch(3'd0, "R2");
    do_switch(3'd4, "R2");
    do_switch(3'd3, "R2");
    do_switch(3'd0, "R2");
    do_switch(3'd1, "R2");

    // R4 invalid selects
    do_ignored(3'd5, 3'd1, "R4");
    do_ignored(3'd6, 3'd1, "R4");
    do_ignored(3'd7, 3'd1, "R4");

    // R5 rewrite of the current select
    do_ignored(3'd1, 3'd1, "R5");

    // R6 write while a switch is running
    f0 = foreign;
    watch_b = 2;
    put_sel(3'd2);
    put_sel(3'd0);
    chk(rd_main[3] == 1'b1, "R6", "still busy after second write", int'(rd_main[3]), 1);
    chk(rd_main[2:0] == 3'd2, "R6", "target unchanged", int'(rd_main[2:0]), 2);
    wait_idle("R6");
    chk(foreign == f0, "R7", "no foreign high phase", foreign - f0, 0);
    watch_a = 2;
    expect_both(3'd2, "R6");

    do_switch(3'd4, "R2");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule